// File: doc/BRIEF.md
# Complementary PWM pair with dead-time insertion

This block produces two pulse-width modulated outputs from a common clock base. An 8-bit prescaler is shared by both channels. Each channel then divides the prescaled tick by a selectable power of two and runs a 16-bit down counter that sets the period. A 16-bit compare value sets the duty. Period and compare values are written into holding buffers. A channel copies those buffers into its working registers only at the end of a period, so a value written while the channel runs never cuts a cycle short.

Each channel can run continuously or stop after a single cycle. At every period end it raises a sticky event flag, and its interrupt line follows that flag when the interrupt is enabled. When paired mode is switched on, channel 0 alone sets the timing. Its waveform and its inverse drive both outputs, and each rising edge is held back by a programmable dead time so that the two outputs are never high together.

Top module: `pwm_dz_pair`

## Requirements
- R1: The prescaler tick fires once every `prescale`+1 clocks. A channel's count clock is that tick divided by 2^`sel`, where `sel` is the channel's 3-bit field of `div_sel` (bits [3c+2:3c] for channel c). Values 0..4 give /1, /2, /4, /8 and /16, and values 5..7 also give /16.
- R2: A running channel loaded with period value N counts N, N-1, ... 0, so one period lasts (N+1) count clocks. On the count clock where the counter is at 0, the channel sets `flag[c]` and starts the next period.
- R3: With dead-time mode off, `pwm_out[c]` is high while the channel runs, the counter is at or below the compare value C, and C is not 0. In each period it is high for (C+1) count clocks when 1 <= C <= N, for the whole period when C >= N, and never when C = 0.
- R4: `wr_data` is captured into the period buffer on a clock with `per_wr[c]` high, and into the compare buffer on a clock with `cmp_wr[c]` high. The running counter and compare value take the buffered values only when the counter passes 0, so the period in progress keeps its old length.
- R5: `irq[c]` is high exactly when `flag[c]` and `irq_en[c]` are both high. A one-clock pulse on `flag_clr[c]` clears the flag. If a new period end arrives in the same clock, the set takes priority.
- R6: With `one_shot[c]` high, the channel runs one period from its enable and then stops with its output low. It sets its flag once, and does not restart until `ch_en[c]` goes low and high again.
- R7: While `ch_en[c]` is low, the channel is stopped and its output is low. On the next enable it loads the period and compare buffers as they stand.
- R8: With `dz_en` high, `pwm_out[0]` follows channel 0's waveform and `pwm_out[1]` follows its inverse while channel 0 runs. Each rising edge is delayed by `dead_time` prescaler ticks. With prescale 0 and a period of T clocks that is high for H clocks, the outputs are high for H-`dead_time` and T-H-`dead_time` clocks per period, and they are never high together.
- R9: With `dz_en` high, channel 1's own configuration and counter have no effect on either output.
- R10: After reset both outputs, both flags and both interrupt lines are low, and every counter and buffer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale | input | 8 | Shared prescaler divide value minus one |
| div_sel | input | 6 | Per-channel divider select, 3 bits per channel |
| ch_en | input | 2 | Channel run enables |
| one_shot | input | 2 | Per-channel one-shot select |
| per_wr | input | 2 | Period buffer write strobes |
| cmp_wr | input | 2 | Compare buffer write strobes |
| wr_data | input | 16 | Shared write data for the buffers |
| dz_en | input | 1 | Paired complementary mode with dead time |
| dead_time | input | 8 | Dead time in prescaler ticks |
| irq_en | input | 2 | Interrupt enables |
| flag_clr | input | 2 | Flag clear strobes |
| pwm_out | output | 2 | PWM outputs |
| flag | output | 2 | Sticky period-end flags |
| irq | output | 2 | Interrupt outputs |

## Verification
A period-end flag appears one clock after the count clock on which the counter sits at 0. A write to a buffer lands at the next edge, and a flag clear takes effect at the edge after the strobe. The bench therefore does not predict the absolute phase after an enable, which depends on where the shared prescaler stands. It synchronises to a flag seen at a falling edge, clears it, and counts clocks and output-high samples at each falling edge until the next flag. This gives a window of exactly one period, whose length and high count the requirement formulas fix no matter where the window starts. The interrupt line is combinational on the flag, so it is sampled one time unit after its enable changes. One-shot and disable results are counted over fixed windows longer than any possible delay.

// File: rtl/pwm_dz_pkg.sv
package pwm_dz_pkg;
   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_RUN  = 2'd1,
      CH_DONE = 2'd2
   } ch_state_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] prescale,
   output logic             tick
);
   logic [PRE_W-1:0] pre_cnt;

   initial begin
      assert (PRE_W >= 1) else $error("PRE_W must be at least 1");
   end

   assign tick = (pre_cnt >= prescale);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_cnt <= '0;
      else if (tick) pre_cnt <= '0;
      else           pre_cnt <= pre_cnt + PRE_W'(1);
   end

   // R1: a tick is never more than prescale+1 clocks after the previous one
   p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> (pre_cnt != '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_dz_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DIV_LOG = 4,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_tick,
   input  logic             en,
   input  logic             one_shot,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             per_wr,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             flag_clr,
   output logic             flag,
   output logic             active,
   output logic             pwm_raw
);
   ch_state_e        state;
   logic [CNT_W-1:0] cnt, per_buf, cmp_buf, cmp_act;
   logic             ch_tick, zero_evt;

   initial begin
      assert (CNT_W >= 2) else $error("CNT_W too small");
      assert (DIV_LOG >= 0 && DIV_LOG < (1 << SEL_W)) else $error("DIV_LOG does not fit SEL_W");
   end

   generate
      if (DIV_LOG == 0) begin : g_nodiv
         assign ch_tick = pre_tick;
      end else begin : g_div
         logic [DIV_LOG-1:0] div_cnt, mask;
         logic [SEL_W-1:0]   sel_eff;
         logic [DIV_LOG:0]   one_hot;
         always_comb begin
            sel_eff = (div_sel > SEL_W'(DIV_LOG)) ? SEL_W'(DIV_LOG) : div_sel;
            one_hot = (DIV_LOG+1)'(1) << sel_eff;
            mask    = one_hot[DIV_LOG-1:0] - DIV_LOG'(1);
         end
         assign ch_tick = pre_tick && ((div_cnt & mask) == mask);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               div_cnt <= '0;
            else if (state != CH_RUN) div_cnt <= '0;
            else if (pre_tick)        div_cnt <= div_cnt + DIV_LOG'(1);
         end
      end
   endgenerate

   assign zero_evt = (state == CH_RUN) && en && ch_tick && (cnt == '0);
   assign active   = (state == CH_RUN);
   assign pwm_raw  = active && (cmp_act != '0) && (cnt <= cmp_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CH_IDLE;
         cnt     <= '0;
         cmp_act <= '0;
         per_buf <= '0;
         cmp_buf <= '0;
         flag    <= 1'b0;
      end else begin
         if (per_wr) per_buf <= wr_data;
         if (cmp_wr) cmp_buf <= wr_data;
         if (zero_evt)      flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         case (state)
            CH_IDLE: if (en) begin
               state   <= CH_RUN;
               cnt     <= per_buf;
               cmp_act <= cmp_buf;
            end
            CH_RUN: begin
               if (!en) state <= CH_IDLE;
               else if (ch_tick) begin
                  if (cnt != '0) cnt <= cnt - CNT_W'(1);
                  else if (one_shot) state <= CH_DONE;
                  else begin
                     cnt     <= per_buf;
                     cmp_act <= cmp_buf;
                  end
               end
            end
            CH_DONE: if (!en) state <= CH_IDLE;
            default: state <= CH_IDLE;
         endcase
      end
   end

   // R2: the flag only rises after the counter sat at zero
   p_flag_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(active && cnt == '0));
   // R7: a disabled channel drives low from the next clock
   p_low_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pwm_raw);
   // R6: a one-shot period end parks the channel
   p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && one_shot) |=> (state == CH_DONE));
   // R4: the working compare value changes only at a start or a period end
   p_cmp_buffered_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !zero_evt) |=> $stable(cmp_act));
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [DT_W-1:0] dead,
   input  logic            din,
   output logic            dout
);
   logic [DT_W-1:0] wait_cnt;

   initial begin
      assert (DT_W >= 1) else $error("DT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= 1'b0;
         wait_cnt <= '0;
      end else if (!din) begin
         dout     <= 1'b0;
         wait_cnt <= '0;
      end else if (!dout) begin
         if (wait_cnt == dead) dout     <= 1'b1;
         else if (tick)        wait_cnt <= wait_cnt + DT_W'(1);
      end
   end

   // R8: output rises only after the input was high through the full dead time
   p_rise_delayed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout) |-> $past(din && wait_cnt == dead));
   // R8: output falls one clock after the input drops
   p_fall_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !din |=> !dout);
endmodule

// File: rtl/pwm_dz_pair.sv
module pwm_dz_pair #(
   parameter int PRE_W   = 8,
   parameter int CNT_W   = 16,
   parameter int DT_W    = 8,
   parameter int DIV_LOG = 4,
   localparam int SEL_W  = (DIV_LOG < 1) ? 1 : $clog2(DIV_LOG + 1),
   localparam int NCH    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRE_W-1:0]   prescale,
   input  logic [NCH*SEL_W-1:0] div_sel,
   input  logic [NCH-1:0]     ch_en,
   input  logic [NCH-1:0]     one_shot,
   input  logic [NCH-1:0]     per_wr,
   input  logic [NCH-1:0]     cmp_wr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic               dz_en,
   input  logic [DT_W-1:0]    dead_time,
   input  logic [NCH-1:0]     irq_en,
   input  logic [NCH-1:0]     flag_clr,
   output logic [NCH-1:0]     pwm_out,
   output logic [NCH-1:0]     flag,
   output logic [NCH-1:0]     irq
);
   logic           pre_tick;
   logic [NCH-1:0] raw, act, dz_src, dz_out;

   pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .prescale(prescale), .tick(pre_tick)
   );

   assign dz_src = {act[0] & ~raw[0], raw[0]};

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         pwm_channel #(.CNT_W(CNT_W), .DIV_LOG(DIV_LOG), .SEL_W(SEL_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
            .en(ch_en[g]), .one_shot(one_shot[g]),
            .div_sel(div_sel[g*SEL_W +: SEL_W]),
            .per_wr(per_wr[g]), .cmp_wr(cmp_wr[g]), .wr_data(wr_data),
            .flag_clr(flag_clr[g]), .flag(flag[g]),
            .active(act[g]), .pwm_raw(raw[g])
         );
         pwm_deadtime #(.DT_W(DT_W)) u_dt (
            .clk(clk), .rst_n(rst_n), .tick(pre_tick), .dead(dead_time),
            .din(dz_src[g]), .dout(dz_out[g])
         );
         assign pwm_out[g] = dz_en ? dz_out[g] : raw[g];
      end
   endgenerate

   assign irq = flag & irq_en;

   // R8: paired outputs never overlap
   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dz_en |-> !(pwm_out[0] && pwm_out[1]));
   // R9: in paired mode output 1 is low whenever channel 0 is stopped
   p_ch1_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dz_en && !act[0] && !$past(act[0])) |-> !pwm_out[1]);
   // R7: disabled channel 1 stops on the next clock
   p_ch1_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[1] |=> !act[1]);
endmodule

// File: tb/pwm_dz_pair_tb.sv
`timescale 1ns/1ps
module pwm_dz_pair_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  prescale = '0;
   logic [5:0]  div_sel = '0;
   logic [1:0]  ch_en = '0, one_shot = '0, per_wr = '0, cmp_wr = '0;
   logic [15:0] wr_data = '0;
   logic        dz_en = 1'b0;
   logic [7:0]  dead_time = '0;
   logic [1:0]  irq_en = '0, flag_clr = '0;
   logic [1:0]  pwm_out, flag, irq;

   int errors = 0, checks = 0, cycles = 0;

   // rows: channel, prescale, sel, period N, compare C, expected clocks, expected high
   localparam int NV = 7;
   localparam int VEC [NV][7] = '{
      '{0, 0, 0, 9, 4, 10, 5},
      '{0, 2, 1, 4, 2, 30, 18},
      '{1, 1, 2, 3, 0, 32, 0},
      '{1, 0, 4, 2, 7, 48, 48},
      '{0, 0, 3, 5, 5, 48, 48},
      '{0, 3, 0, 7, 1, 32, 8},
      '{1, 1, 5, 2, 1, 96, 64}
   };

   pwm_dz_pair dut_i (
      .clk(clk), .rst_n(rst_n), .prescale(prescale), .div_sel(div_sel),
      .ch_en(ch_en), .one_shot(one_shot), .per_wr(per_wr), .cmp_wr(cmp_wr),
      .wr_data(wr_data), .dz_en(dz_en), .dead_time(dead_time),
      .irq_en(irq_en), .flag_clr(flag_clr), .pwm_out(pwm_out),
      .flag(flag), .irq(irq)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr_buf(input int ch, input bit is_cmp, input int val);
      wr_data = 16'(val);
      if (is_cmp) cmp_wr[ch] = 1'b1; else per_wr[ch] = 1'b1;
      @(negedge clk);
      cmp_wr = '0;
      per_wr = '0;
   endtask

   task automatic setup_ch(input int ch, input int p, input int s, input int n, input int c);
      ch_en[ch] = 1'b0;
      @(negedge clk);
      prescale = 8'(p);
      div_sel[ch*3 +: 3] = 3'(s);
      wr_buf(ch, 1'b0, n);
      wr_buf(ch, 1'b1, c);
      ch_en[ch] = 1'b1;
      @(negedge clk);
   endtask

   // wait for the flag at a falling edge, then clear it (one clock used)
   task automatic sync_flag(input int ch);
      int guard = 0;
      while (flag[ch] !== 1'b1 && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      flag_clr[ch] = 1'b1;
      @(negedge clk);
      flag_clr[ch] = 1'b0;
   endtask

   task automatic count_period(input int ch, input int n0, output int n,
                               output int h0, output int h1, output int both);
      n = n0; h0 = int'(pwm_out[0]); h1 = int'(pwm_out[1]);
      both = int'(pwm_out[0] & pwm_out[1]);
      while (flag[ch] !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
         h0 += int'(pwm_out[0]);
         h1 += int'(pwm_out[1]);
         both += int'(pwm_out[0] & pwm_out[1]);
      end
   endtask

   task automatic measure(input int ch, output int n, output int h0,
                          output int h1, output int both);
      sync_flag(ch);
      count_period(ch, 1, n, h0, h1, both);
   endtask

   task automatic count_high(input int ch, input int len, output int h);
      h = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         h += int'(pwm_out[ch]);
      end
   endtask

   initial begin
      int n, h0, h1, both, h;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 pwm_out after reset", int'(pwm_out), 0);
      chk("R10 flag after reset", int'(flag), 0);
      chk("R10 irq after reset", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R7: vector table, buffers loaded on each fresh enable
      for (int v = 0; v < NV; v++) begin
         setup_ch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
         sync_flag(VEC[v][0]);
         measure(VEC[v][0], n, h0, h1, both);
         chk($sformatf("R1/R2 row %0d period clocks", v), n, VEC[v][5]);
         chk($sformatf("R3 row %0d high clocks", v),
             (VEC[v][0] == 0) ? h0 : h1, VEC[v][6]);
      end
      ch_en = '0;
      @(negedge clk);

      // R4: period write mid-period affects only the next period
      setup_ch(0, 0, 0, 9, 4);
      sync_flag(0);
      sync_flag(0);
      wr_buf(0, 1'b0, 19);
      count_period(0, 2, n, h0, h1, both);
      chk("R4 old period kept after write", n, 10);
      measure(0, n, h0, h1, both);
      chk("R4 new period after boundary", n, 20);
      chk("R4 compare unchanged", h0, 5);

      // R5: interrupt gating and flag clear
      irq_en = 2'b00;
      begin
         int guard = 0;
         while (flag[0] !== 1'b1 && guard < 100) begin
            @(negedge clk);
            guard++;
         end
      end
      chk("R5 irq masked", int'(irq[0]), 0);
      irq_en[0] = 1'b1;
      #1;
      chk("R5 irq follows flag", int'(irq[0]), 1);
      flag_clr[0] = 1'b1;
      @(negedge clk);
      flag_clr[0] = 1'b0;
      chk("R5 flag cleared", int'(flag[0]), 0);
      chk("R5 irq cleared", int'(irq[0]), 0);
      irq_en = '0;

      // R7: disabled channel output held low
      ch_en[0] = 1'b0;
      @(negedge clk);
      count_high(0, 40, h);
      chk("R7 disabled output low", h, 0);

      // R6: one-shot on channel 1
      prescale = 8'd0;
      div_sel[5:3] = 3'd0;
      one_shot[1] = 1'b1;
      wr_buf(1, 1'b0, 3);
      wr_buf(1, 1'b1, 1);
      flag_clr[1] = 1'b1;
      @(negedge clk);
      flag_clr[1] = 1'b0;
      ch_en[1] = 1'b1;
      count_high(1, 30, h);
      chk("R6 single cycle high clocks", h, 2);
      chk("R6 flag set once", int'(flag[1]), 1);
      flag_clr[1] = 1'b1;
      @(negedge clk);
      flag_clr[1] = 1'b0;
      count_high(1, 30, h);
      chk("R6 no restart output", h, 0);
      chk("R6 no second flag", int'(flag[1]), 0);
      ch_en[1] = 1'b0;
      one_shot[1] = 1'b0;
      @(negedge clk);

      // R8 R9: paired mode, channel 1 busy with another setting
      setup_ch(1, 0, 2, 3, 1);
      setup_ch(0, 0, 0, 9, 4);
      dead_time = 8'd2;
      dz_en = 1'b1;
      sync_flag(0);
      measure(0, n, h0, h1, both);
      chk("R8 paired period", n, 10);
      chk("R8 output 0 high with dead time 2", h0, 3);
      chk("R8 output 1 high with dead time 2", h1, 3);
      chk("R8 no overlap", both, 0);
      dead_time = 8'd0;
      sync_flag(0);
      measure(0, n, h0, h1, both);
      chk("R8 output 0 high with dead time 0", h0, 5);
      chk("R8 output 1 high with dead time 0", h1, 5);
      wr_buf(1, 1'b0, 7);
      div_sel[5:3] = 3'd0;
      dead_time = 8'd2;
      sync_flag(0);
      sync_flag(0);
      count_period(0, 1, n, h0, h1, both);
      chk("R9 period unaffected by channel 1", n, 10);
      chk("R9 output 0 unaffected", h0, 3);
      chk("R9 output 1 unaffected", h1, 3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule